// File: doc/BRIEF.md
# Instruction group completion tracker

This block keeps track of operations that are dispatched in bundles. Each cycle the dispatch side may offer one group of up to five operations in program order, described by a five-bit membership mask. An accepted group takes the next slot of a twenty-entry circular table. That slot number is the group id, and the dispatch side hands it to every member operation. The execution units then report finished operations out of order, up to ten per cycle. Each report carries a group id and a member slot index. The block gathers these reports back into their groups and retires whole groups strictly in program order: a group leaves only when it is the oldest in the table and every member named in its mask has finished.

Two state machines drive the table. Each entry runs its own machine. An entry in FREE moves to WAIT when it is allocated, or straight to DONE if its mask is empty. In WAIT it moves to DONE once the last member is reported. It goes from DONE back to FREE when it retires, and from WAIT or DONE back to FREE when a flush kills it. The table controller has three states, EMPTY, PARTIAL and FULL, and moves between them as the occupancy reaches zero, leaves zero, reaches twenty or drops below twenty. Dispatch is refused in FULL. A flush names a group id. That group and every younger group are discarded in one cycle, and the allocation point moves back to the flushed id. This supports recovery after a misprediction.

Top module: `group_tracker`

## Requirements
- R1: While reset is asserted and right after it: occupancy is 0, disp_ready is 1, retire_valid is 0, cmpl_err is 0, and disp_id shows 0.
- R2: A group is accepted at a rising edge where disp_valid and disp_ready are both 1. It receives the id shown on disp_id in that cycle. Ids are handed out 0, 1, …, 19 and then wrap to 0. Each accepted group raises occupancy by one unless a retirement happens at the same edge.
- R3: When 20 groups are held, disp_ready is 0. A disp_valid pulse in that state changes neither occupancy nor disp_id.
- R4: A completion port p with cmpl_valid[p]=1 marks member slot cmpl_slot[p] of group cmpl_id[p]. Bit s of disp_mask is member slot s. Reports may arrive in any order, and all ten ports may report in the same cycle, including all five members of two groups.
- R5: A group is complete once every slot set in its mask has been reported. Reports for slots outside the mask do not count toward completion. A group dispatched with mask 0 is complete at once.
- R6: Only the oldest group retires, and at most one group retires per cycle. A complete younger group waits. retire_valid is 1 for exactly one cycle per group, carrying retire_id and retire_mask, and starts in the cycle after the edge that records the last member of the oldest group. If the group becomes the oldest later, retire_valid starts in the cycle after the edge at which it does.
- R7: Each retirement lowers occupancy by one. A retirement and a dispatch at the same edge leave occupancy unchanged.
- R8: flush_valid=1 with an allocated flush_id frees that group and all younger groups at the next edge. occupancy becomes the number of older groups, and disp_id becomes flush_id. In a cycle with flush_valid=1, disp_ready is 0 and no group retires. Reports to freed ids then count as reports to unallocated ids.
- R9: A flush naming an id that is not allocated has no effect on occupancy or disp_id.
- R10: A completion report whose id is not allocated, including ids 20 to 31, is ignored. cmpl_err is 1 in exactly the cycle after any such report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A group is offered for dispatch |
| disp_mask | input | 5 | Membership mask of the offered group, bit s is slot s |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_id | output | 5 | Id the offered group would receive |
| cmpl_valid | input | 10 | Per-port completion report strobe |
| cmpl_id | input | 50 | Group id per port, port p at bits 5p+4:5p |
| cmpl_slot | input | 30 | Member slot per port, port p at bits 3p+2:3p |
| flush_valid | input | 1 | Discard the named group and all younger ones |
| flush_id | input | 5 | Oldest group id to discard |
| retire_valid | output | 1 | The oldest group retires this cycle |
| retire_id | output | 5 | Id of the retiring group |
| retire_mask | output | 5 | Membership mask of the retiring group |
| cmpl_err | output | 1 | A report to an unallocated id occurred last cycle |
| occupancy | output | 5 | Number of allocated groups |

## Verification
The assertions watch the occupancy bookkeeping on every cycle. They check that the occupancy stays within twenty and rises by one on a lone dispatch. They check that the occupancy falls by one on a lone retirement and that a flush moves the allocation point to the flushed id. They also check that an allocated entry starts waiting and that a finished entry keeps its state until it is freed. Only the bench scenarios can show the order of retirements: the scoreboard compares each retired id and mask against dispatch order with flushed groups removed. The scenarios also cover out-of-order completion held behind an unfinished oldest group and reports to non-member slots. They cover ten completions in one cycle, the full-table refusal, the error pulse and flushes of a middle group, the oldest group and an unallocated id.

// File: rtl/gct_pkg.sv
package gct_pkg;

    // Life cycle of one table entry
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_DONE = 2'd2
    } entry_state_e;

    // Fill level of the whole table
    typedef enum logic [1:0] {
        TBL_EMPTY   = 2'd0,
        TBL_PARTIAL = 2'd1,
        TBL_FULL    = 2'd2
    } table_state_e;

endpackage

// File: rtl/gct_entry.sv
module gct_entry
    import gct_pkg::*;
#(
    parameter int GROUP_SIZE = 5,
    parameter int NUM_PORTS  = 10,
    parameter int ID_W       = 5,
    parameter int SLOT_W     = 3,
    parameter int ENTRY_ID   = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc,
    input  logic [GROUP_SIZE-1:0]       alloc_mask,
    input  logic                        release_i,
    input  logic [NUM_PORTS-1:0]        cmpl_valid,
    input  logic [NUM_PORTS*ID_W-1:0]   cmpl_id,
    input  logic [NUM_PORTS*SLOT_W-1:0] cmpl_slot,
    output logic                        busy,
    output logic                        finished,
    output logic [GROUP_SIZE-1:0]       member_mask
);

    entry_state_e          st_q, st_d;
    logic [GROUP_SIZE-1:0] mask_q;
    logic [GROUP_SIZE-1:0] seen_q, seen_d;
    logic [GROUP_SIZE-1:0] hit;

    // Gather this cycle's reports that address this entry
    always_comb begin
        hit = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cmpl_valid[p] && cmpl_id[p*ID_W +: ID_W] == ID_W'(ENTRY_ID)) begin
                for (int s = 0; s < GROUP_SIZE; s++) begin
                    if (cmpl_slot[p*SLOT_W +: SLOT_W] == SLOT_W'(s)) hit[s] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        seen_d = seen_q;
        if (alloc)                 seen_d = '0;
        else if (st_q == ENT_WAIT) seen_d = seen_q | (hit & mask_q);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ENT_FREE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ENT_FREE: begin
                if (alloc) st_d = (alloc_mask == '0) ? ENT_DONE : ENT_WAIT;
            end
            ENT_WAIT: begin
                if (release_i)             st_d = ENT_FREE;
                else if (seen_d == mask_q) st_d = ENT_DONE;
            end
            ENT_DONE: begin
                if (release_i) st_d = ENT_FREE;
            end
            default: st_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            seen_q <= '0;
        end else begin
            seen_q <= seen_d;
            if (alloc) mask_q <= alloc_mask;
        end
    end

    // Outputs
    always_comb begin
        busy        = (st_q != ENT_FREE);
        finished    = (st_q == ENT_DONE);
        member_mask = mask_q;
    end

    // R5
    alloc_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && alloc_mask != '0) |=> (busy && !finished));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finished && !release_i) |=> finished);

endmodule

// File: rtl/gct_ctrl.sv
module gct_ctrl
    import gct_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ID_W       = 5,
    parameter int CNT_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  disp_valid,
    input  logic                  flush_valid,
    input  logic [ID_W-1:0]       flush_id,
    input  logic                  flush_hit,
    input  logic                  head_done,
    output logic                  disp_ready,
    output logic                  disp_fire,
    output logic                  retire_fire,
    output logic                  flush_fire,
    output logic [ID_W-1:0]       head,
    output logic [ID_W-1:0]       tail,
    output logic [CNT_W-1:0]      count,
    output logic [NUM_GROUPS-1:0] kill
);

    table_state_e   st_q, st_d;
    logic [CNT_W-1:0] count_d;

    function automatic logic [ID_W-1:0] step(input logic [ID_W-1:0] p);
        return (int'(p) == NUM_GROUPS - 1) ? '0 : p + 1'b1;
    endfunction

    // Distance from b forward to a around the ring
    function automatic int span(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b);
        return (a >= b) ? int'(a) - int'(b) : int'(a) + NUM_GROUPS - int'(b);
    endfunction

    // Outputs derived from the table state
    always_comb begin
        disp_ready  = (st_q != TBL_FULL) && !flush_valid;
        disp_fire   = disp_valid && disp_ready;
        flush_fire  = flush_valid && flush_hit;
        retire_fire = head_done && !flush_valid && (st_q != TBL_EMPTY);
    end

    always_comb begin
        if (flush_fire) count_d = CNT_W'(span(flush_id, head));
        else            count_d = count + CNT_W'(disp_fire) - CNT_W'(retire_fire);
    end

    // Entries from the flushed id up to the youngest
    always_comb begin
        for (int i = 0; i < NUM_GROUPS; i++) begin
            int d;
            d = span(ID_W'(i), head);
            kill[i] = flush_fire && (d >= span(flush_id, head)) && (d < int'(count));
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TBL_EMPTY;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TBL_EMPTY: begin
                if (disp_fire) st_d = (NUM_GROUPS == 1) ? TBL_FULL : TBL_PARTIAL;
            end
            TBL_PARTIAL: begin
                if (count_d == '0)                       st_d = TBL_EMPTY;
                else if (count_d == CNT_W'(NUM_GROUPS))  st_d = TBL_FULL;
            end
            TBL_FULL: begin
                if (count_d == '0)                       st_d = TBL_EMPTY;
                else if (count_d != CNT_W'(NUM_GROUPS))  st_d = TBL_PARTIAL;
            end
            default: st_d = TBL_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            count <= count_d;
            if (retire_fire) head <= step(head);
            if (flush_fire)     tail <= flush_id;
            else if (disp_fire) tail <= step(tail);
        end
    end

    // R3
    occupancy_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(NUM_GROUPS));

    // R2
    disp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire && !retire_fire && !flush_fire) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R8
    flush_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fire |=> (tail == $past(flush_id)));

endmodule

// File: rtl/group_tracker.sv
module group_tracker #(
    parameter  int NUM_GROUPS = 20,
    parameter  int GROUP_SIZE = 5,
    parameter  int NUM_PORTS  = 10,
    localparam int ID_W       = $clog2(NUM_GROUPS),
    localparam int SLOT_W     = $clog2(GROUP_SIZE),
    localparam int CNT_W      = $clog2(NUM_GROUPS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        disp_valid,
    input  logic [GROUP_SIZE-1:0]       disp_mask,
    output logic                        disp_ready,
    output logic [ID_W-1:0]             disp_id,
    input  logic [NUM_PORTS-1:0]        cmpl_valid,
    input  logic [NUM_PORTS*ID_W-1:0]   cmpl_id,
    input  logic [NUM_PORTS*SLOT_W-1:0] cmpl_slot,
    input  logic                        flush_valid,
    input  logic [ID_W-1:0]             flush_id,
    output logic                        retire_valid,
    output logic [ID_W-1:0]             retire_id,
    output logic [GROUP_SIZE-1:0]       retire_mask,
    output logic                        cmpl_err,
    output logic [CNT_W-1:0]            occupancy
);

    logic                  disp_fire, retire_fire, flush_fire;
    logic                  flush_hit, head_done;
    logic [ID_W-1:0]       head, tail;
    logic [CNT_W-1:0]      count;
    logic [NUM_GROUPS-1:0] kill;
    logic [NUM_GROUPS-1:0] ent_busy, ent_done;
    logic [GROUP_SIZE-1:0] ent_mask [NUM_GROUPS];
    logic [NUM_PORTS-1:0]  stray;
    logic                  err_q;

    gct_ctrl #(
        .NUM_GROUPS (NUM_GROUPS),
        .ID_W       (ID_W),
        .CNT_W      (CNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .disp_valid  (disp_valid),
        .flush_valid (flush_valid),
        .flush_id    (flush_id),
        .flush_hit   (flush_hit),
        .head_done   (head_done),
        .disp_ready  (disp_ready),
        .disp_fire   (disp_fire),
        .retire_fire (retire_fire),
        .flush_fire  (flush_fire),
        .head        (head),
        .tail        (tail),
        .count       (count),
        .kill        (kill)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_entry
        gct_entry #(
            .GROUP_SIZE (GROUP_SIZE),
            .NUM_PORTS  (NUM_PORTS),
            .ID_W       (ID_W),
            .SLOT_W     (SLOT_W),
            .ENTRY_ID   (g)
        ) entry_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (disp_fire && tail == ID_W'(g)),
            .alloc_mask  (disp_mask),
            .release_i   ((retire_fire && head == ID_W'(g)) || kill[g]),
            .cmpl_valid  (cmpl_valid),
            .cmpl_id     (cmpl_id),
            .cmpl_slot   (cmpl_slot),
            .busy        (ent_busy[g]),
            .finished    (ent_done[g]),
            .member_mask (ent_mask[g])
        );
    end

    // Select per-id status; ids past the table end read as free
    always_comb begin
        flush_hit   = 1'b0;
        head_done   = 1'b0;
        retire_mask = '0;
        for (int i = 0; i < NUM_GROUPS; i++) begin
            if (flush_id == ID_W'(i)) flush_hit = ent_busy[i];
            if (head == ID_W'(i)) begin
                head_done   = ent_done[i];
                retire_mask = ent_mask[i];
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            logic owned;
            owned = 1'b0;
            for (int i = 0; i < NUM_GROUPS; i++) begin
                if (cmpl_id[p*ID_W +: ID_W] == ID_W'(i)) owned = ent_busy[i];
            end
            stray[p] = cmpl_valid[p] && !owned;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= |stray;
    end

    always_comb begin
        disp_id      = tail;
        retire_valid = retire_fire;
        retire_id    = head;
        cmpl_err     = err_q;
        occupancy    = count;
    end

    // R7
    retire_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && !(disp_valid && disp_ready)) |=> (occupancy == CNT_W'($past(occupancy) - 1'b1)));

endmodule

// File: tb/group_tracker_tb_top.sv
module group_tracker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [4:0]  disp_mask = '0;
    logic        disp_ready;
    logic [4:0]  disp_id;
    logic [9:0]  cmpl_valid = '0;
    logic [49:0] cmpl_id = '0;
    logic [29:0] cmpl_slot = '0;
    logic        flush_valid = 1'b0;
    logic [4:0]  flush_id = '0;
    logic        retire_valid;
    logic [4:0]  retire_id;
    logic [4:0]  retire_mask;
    logic        cmpl_err;
    logic [4:0]  occupancy;

    int n_checks = 0;
    int n_fails  = 0;
    int tail_m   = 0;
    int cnt_m    = 0;
    logic [9:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    group_tracker dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .disp_valid   (disp_valid),
        .disp_mask    (disp_mask),
        .disp_ready   (disp_ready),
        .disp_id      (disp_id),
        .cmpl_valid   (cmpl_valid),
        .cmpl_id      (cmpl_id),
        .cmpl_slot    (cmpl_slot),
        .flush_valid  (flush_valid),
        .flush_id     (flush_id),
        .retire_valid (retire_valid),
        .retire_id    (retire_id),
        .retire_mask  (retire_mask),
        .cmpl_err     (cmpl_err),
        .occupancy    (occupancy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Monitor: retirements must follow the scoreboard order (R6)
    always @(negedge clk) begin
        if (rst_n && retire_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected retire id", int'(retire_id), -1);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                check(retire_id == e[9:5], "R6 retire id", int'(retire_id), int'(e[9:5]));
                check(retire_mask == e[4:0], "R6 retire mask", int'(retire_mask), int'(e[4:0]));
                cnt_m--;
            end
        end
    end

    // All tasks start and end one time unit after a rising edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic dispatch(input logic [4:0] m);
        check(disp_ready == 1'b1, "R2 ready before dispatch", int'(disp_ready), 1);
        check(int'(disp_id) == tail_m, "R2 disp_id", int'(disp_id), tail_m);
        disp_valid = 1'b1;
        disp_mask  = m;
        tick(1);
        disp_valid = 1'b0;
        exp_q.push_back({5'(tail_m), m});
        tail_m = (tail_m + 1) % NG;
        cnt_m++;
    endtask

    task automatic report(input int id, input int slot);
        cmpl_valid = 10'b1;
        cmpl_id[4:0]   = 5'(id);
        cmpl_slot[2:0] = 3'(slot);
        tick(1);
        cmpl_valid = '0;
    endtask

    task automatic report_bad(input int id, input string req);
        report(id, 0);
        check(cmpl_err == 1'b1, req, int'(cmpl_err), 1);
        tick(1);
        check(cmpl_err == 1'b0, {req, " pulse end"}, int'(cmpl_err), 0);
    endtask

    // Slots 0 and 1 of five consecutive groups, ten ports in one cycle
    task automatic report_pairs(input int g0);
        for (int p = 0; p < 10; p++) begin
            cmpl_id[p*5 +: 5]   = 5'((g0 + p/2) % NG);
            cmpl_slot[p*3 +: 3] = 3'(p % 2);
        end
        cmpl_valid = '1;
        tick(1);
        cmpl_valid = '0;
    endtask

    // All five members of two groups in one cycle
    task automatic report_two_full(input int a, input int b);
        for (int p = 0; p < 10; p++) begin
            cmpl_id[p*5 +: 5]   = 5'((p < 5) ? a : b);
            cmpl_slot[p*3 +: 3] = 3'(p % 5);
        end
        cmpl_valid = '1;
        tick(1);
        cmpl_valid = '0;
    endtask

    task automatic flush(input int id, input int new_cnt, input bit hit);
        flush_valid = 1'b1;
        flush_id    = 5'(id);
        #1;
        check(disp_ready == 1'b0, "R8 ready low during flush", int'(disp_ready), 0);
        check(retire_valid == 1'b0, "R8 no retire during flush", int'(retire_valid), 0);
        tick(1);
        flush_valid = 1'b0;
        if (hit) begin
            for (int k = 0; k < cnt_m - new_cnt; k++) void'(exp_q.pop_back());
            cnt_m  = new_cnt;
            tail_m = id;
            check(int'(occupancy) == new_cnt, "R8 occupancy after flush", int'(occupancy), new_cnt);
            check(int'(disp_id) == id, "R8 disp_id after flush", int'(disp_id), id);
        end else begin
            check(int'(occupancy) == cnt_m, "R9 occupancy after stray flush", int'(occupancy), cnt_m);
            check(int'(disp_id) == tail_m, "R9 disp_id after stray flush", int'(disp_id), tail_m);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        tick(3);
        // R1 reset state
        check(occupancy == 5'd0, "R1 occupancy", int'(occupancy), 0);
        check(disp_ready == 1'b1, "R1 disp_ready", int'(disp_ready), 1);
        check(retire_valid == 1'b0, "R1 retire_valid", int'(retire_valid), 0);
        check(cmpl_err == 1'b0, "R1 cmpl_err", int'(cmpl_err), 0);
        check(disp_id == 5'd0, "R1 disp_id", int'(disp_id), 0);
        rst_n = 1'b1;
        tick(1);

        // R4 out-of-order completion, R6 held behind the oldest group
        dispatch(5'b11111);
        dispatch(5'b00101);
        dispatch(5'b00001);
        report(1, 2);
        report(1, 0);
        tick(2);
        check(retire_valid == 1'b0, "R6 younger waits", int'(retire_valid), 0);
        report(0, 4);
        report(0, 2);
        report(0, 3);
        report(0, 1);
        check(retire_valid == 1'b0, "R4 partial group", int'(retire_valid), 0);
        report(0, 0);
        check(retire_valid == 1'b1, "R6 retire timing", int'(retire_valid), 1);
        tick(3);
        check(int'(occupancy) == 1, "R7 occupancy after retires", int'(occupancy), 1);

        // R5 non-member slot does not count
        report(2, 3);
        tick(1);
        check(retire_valid == 1'b0, "R5 non-member ignored", int'(retire_valid), 0);
        report(2, 0);
        tick(2);

        // R5 empty mask completes at once
        dispatch(5'b00000);
        tick(2);
        check(int'(occupancy) == 0, "R5 empty group retired", int'(occupancy), 0);

        // R10 reports to unallocated ids
        report_bad(7, "R10 free id error");
        report_bad(25, "R10 out-of-range id error");
        check(int'(occupancy) == 0, "R10 occupancy unchanged", int'(occupancy), 0);

        // R3 fill the table, ids wrap 19 to 0
        for (int k = 0; k < NG; k++) dispatch(5'b00011);
        check(int'(occupancy) == NG, "R3 full occupancy", int'(occupancy), NG);
        check(disp_ready == 1'b0, "R3 ready low when full", int'(disp_ready), 0);
        disp_valid = 1'b1;
        disp_mask  = 5'b00001;
        tick(1);
        disp_valid = 1'b0;
        check(int'(occupancy) == NG, "R3 refused dispatch occupancy", int'(occupancy), NG);
        check(int'(disp_id) == tail_m, "R3 refused dispatch id", int'(disp_id), tail_m);

        // R8 flush a middle group; groups 4..13 stay
        flush(14, 10, 1'b1);
        report_bad(15, "R8 report to flushed id");
        flush(16, 0, 1'b0);

        // R4 ten reports per cycle drain the remaining groups in order
        report_pairs(4);
        report_pairs(9);
        tick(12);
        check(int'(occupancy) == 0, "R7 drained", int'(occupancy), 0);

        // R4 two whole groups finished in one cycle
        dispatch(5'b11111);
        dispatch(5'b11111);
        report_two_full(14, 15);
        tick(3);
        check(int'(occupancy) == 0, "R4 both groups retired", int'(occupancy), 0);

        // R7 retire and dispatch at the same edge
        dispatch(5'b00001);
        report(16, 0);
        check(retire_valid == 1'b1, "R7 retire present", int'(retire_valid), 1);
        dispatch(5'b00010);
        check(int'(occupancy) == 1, "R7 simultaneous retire and dispatch", int'(occupancy), 1);

        // R8 flush the oldest group empties the table
        flush(17, 0, 1'b1);
        tick(3);
        check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
        summary();
    end

endmodule